// File: doc/BRIEF.md
# Dataflow Graph Mapping Distributor

This block sits between the program loader and an 8 by 8 grid of processing elements. Each element has its own activation frame store. While the array is in load mode, the loader offers one 144-bit instruction frame per cycle with a valid/ready handshake. Each offer carries a mapping selector, a column coordinate, a row coordinate, a 10-bit slot number and two 8-bit masks.

The block decodes the selector and drives one registered write strobe per element, together with a shared slot number and frame. The strobe, slot and frame reach the stores one cycle after the loader's offer is accepted. There are three ways to place a frame:
- on one element chosen by its coordinates,
- on every element at once,
- on the subset of elements picked by crossing a column mask with a row mask.

The selector is taken fresh with every frame, so the loader can mix the three placements freely without idle cycles.

Top module: `frame_map_distributor`

## Requirements
- R1: After reset, all 64 write strobes are 0.
- R2: `in_ready` follows `load_en`. While `load_en` is 0, no frame is accepted, and in the following cycle every write strobe is 0.
- R3: Selector 2'b00 (single target): the cycle after acceptance, exactly strobe bit `y*8+x` is 1, where `x` = `in_col` and `y` = `in_row`.
- R4: Selector 2'b01 (broadcast): the cycle after acceptance, all 64 strobes are 1, whatever the values of `in_col` and `in_row`.
- R5: Selector 2'b10 (masked): the cycle after acceptance, strobe bit `y*8+x` is 1 exactly when bit `x` of `in_colmask` and bit `y` of `in_rowmask` are both 1.
- R6: Selector 2'b11 is illegal. An accepted frame with this selector raises no strobe.
- R7: The selector may differ on consecutive accepted frames, and each frame is placed by its own selector with no idle cycle in between.
- R8: Strobes last one cycle. In a cycle after one without an accepted frame, all strobes are 0.
- R9: In the cycle when strobes for an accepted frame are raised, `wr_slot` equals that frame's `in_slot` and `wr_frame` equals its `in_frame`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Array is in load mode |
| in_valid | input | 1 | Loader offers a frame |
| in_ready | output | 1 | Distributor can take a frame |
| in_mode | input | 2 | Placement selector: 00 single, 01 broadcast, 10 masked, 11 illegal |
| in_col | input | 3 | Column coordinate of the target element |
| in_row | input | 3 | Row coordinate of the target element |
| in_slot | input | 10 | Slot inside each store |
| in_colmask | input | 8 | Column mask for masked placement |
| in_rowmask | input | 8 | Row mask for masked placement |
| in_frame | input | 144 | Instruction frame |
| wr_en | output | 64 | Per-element write strobe, bit index row*8+column |
| wr_slot | output | 10 | Slot number shared by all stores |
| wr_frame | output | 144 | Frame shared by all stores |

## Verification
On every cycle, the assertions check the following:
- the strobe count in single mode is exactly one;
- broadcast fills all 64 strobes;
- the illegal code and load-mode-off both leave the strobes silent;
- strobes fall after a cycle with no transfer;
- the slot output tracks the accepted slot.

Only the bench scenarios can show which element each coordinate pair and each mask pair picks, since that needs a map computed independently. The same holds for whether a mode switch between back-to-back frames lands each frame under its own selector.

// File: rtl/map_pkg.sv
package map_pkg;
    typedef enum logic [1:0] {
        MAP_SINGLE = 2'b00,
        MAP_ALL    = 2'b01,
        MAP_MASK   = 2'b10,
        MAP_BAD    = 2'b11
    } map_mode_e;
endpackage

// File: rtl/map_axis_decode.sv
module map_axis_decode #(
    parameter int N = 8,
    localparam int W = $clog2(N)
) (
    input  logic [W-1:0] idx,
    output logic [N-1:0] onehot
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign onehot[i] = (idx == W'(i));
    end
endmodule

// File: rtl/map_target_decode.sv
module map_target_decode
    import map_pkg::*;
#(
    parameter int COLS = 8,
    parameter int ROWS = 8,
    localparam int XW  = $clog2(COLS),
    localparam int YW  = $clog2(ROWS),
    localparam int NPE = COLS * ROWS
) (
    input  map_mode_e          mode,
    input  logic [XW-1:0]      col,
    input  logic [YW-1:0]      row,
    input  logic [COLS-1:0]    colmask,
    input  logic [ROWS-1:0]    rowmask,
    output logic [NPE-1:0]     sel
);
    logic [COLS-1:0] col_oh;
    logic [ROWS-1:0] row_oh;
    logic            is_single;
    logic            is_all;
    logic            is_mask;

    map_axis_decode #(.N(COLS)) u_col (.idx(col), .onehot(col_oh));
    map_axis_decode #(.N(ROWS)) u_row (.idx(row), .onehot(row_oh));

    assign is_single = (mode == MAP_SINGLE);
    assign is_all    = (mode == MAP_ALL);
    assign is_mask   = (mode == MAP_MASK);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            assign sel[r*COLS + c] = (is_single & col_oh[c] & row_oh[r])
                                   | is_all
                                   | (is_mask & colmask[c] & rowmask[r]);
        end
    end
endmodule

// File: rtl/frame_map_distributor.sv
module frame_map_distributor
    import map_pkg::*;
#(
    parameter int COLS    = 8,
    parameter int ROWS    = 8,
    parameter int SLOT_W  = 10,
    parameter int FRAME_W = 144,
    localparam int XW     = $clog2(COLS),
    localparam int YW     = $clog2(ROWS),
    localparam int NPE    = COLS * ROWS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [1:0]         in_mode,
    input  logic [XW-1:0]      in_col,
    input  logic [YW-1:0]      in_row,
    input  logic [SLOT_W-1:0]  in_slot,
    input  logic [COLS-1:0]    in_colmask,
    input  logic [ROWS-1:0]    in_rowmask,
    input  logic [FRAME_W-1:0] in_frame,
    output logic [NPE-1:0]     wr_en,
    output logic [SLOT_W-1:0]  wr_slot,
    output logic [FRAME_W-1:0] wr_frame
);
    typedef struct packed {
        logic [NPE-1:0]     en;
        logic [SLOT_W-1:0]  slot;
        logic [FRAME_W-1:0] frame;
    } dist_state_t;

    dist_state_t    st_d, st_q;
    logic [NPE-1:0] sel;
    logic           take;

    map_target_decode #(.COLS(COLS), .ROWS(ROWS)) u_dec (
        .mode    (map_mode_e'(in_mode)),
        .col     (in_col),
        .row     (in_row),
        .colmask (in_colmask),
        .rowmask (in_rowmask),
        .sel     (sel)
    );

    assign in_ready = load_en;
    assign take     = in_valid & load_en;

    always_comb begin
        st_d    = st_q;
        st_d.en = '0;
        if (take) begin
            st_d.en    = sel;
            st_d.slot  = in_slot;
            st_d.frame = in_frame;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en    = st_q.en;
    assign wr_slot  = st_q.slot;
    assign wr_frame = st_q.frame;
endmodule

// File: rtl/map_dist_checker.sv
module map_dist_checker #(
    parameter int COLS    = 8,
    parameter int ROWS    = 8,
    parameter int SLOT_W  = 10,
    parameter int FRAME_W = 144,
    localparam int XW     = $clog2(COLS),
    localparam int YW     = $clog2(ROWS),
    localparam int NPE    = COLS * ROWS
) (
    input logic               clk,
    input logic               rst_n,
    input logic               load_en,
    input logic               in_valid,
    input logic               in_ready,
    input logic [1:0]         in_mode,
    input logic [XW-1:0]      in_col,
    input logic [YW-1:0]      in_row,
    input logic [SLOT_W-1:0]  in_slot,
    input logic [COLS-1:0]    in_colmask,
    input logic [ROWS-1:0]    in_rowmask,
    input logic [FRAME_W-1:0] in_frame,
    input logic [NPE-1:0]     wr_en,
    input logic [SLOT_W-1:0]  wr_slot,
    input logic [FRAME_W-1:0] wr_frame
);
    logic acc;
    assign acc = in_valid && in_ready;

    // R2
    p_quiet_when_unloaded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> (wr_en == '0));
    // R3
    p_single_one_hot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_mode == 2'b00) |=> ($countones(wr_en) == 1));
    // R4
    p_broadcast_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_mode == 2'b01) |=> (&wr_en));
    // R6
    p_illegal_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_mode == 2'b11) |=> (wr_en == '0));
    // R8
    p_strobe_single_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> (wr_en == '0));
    // R9
    p_slot_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (wr_slot == $past(in_slot) && wr_frame == $past(in_frame)));
endmodule

bind frame_map_distributor map_dist_checker #(
    .COLS(COLS), .ROWS(ROWS), .SLOT_W(SLOT_W), .FRAME_W(FRAME_W)
) u_chk (.*);

// File: tb/sim_frame_map_distributor.sv
module sim_frame_map_distributor;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_en = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [1:0]   in_mode = 2'b00;
    logic [2:0]   in_col = '0;
    logic [2:0]   in_row = '0;
    logic [9:0]   in_slot = '0;
    logic [7:0]   in_colmask = '0;
    logic [7:0]   in_rowmask = '0;
    logic [143:0] in_frame = '0;
    logic [63:0]  wr_en;
    logic [9:0]   wr_slot;
    logic [143:0] wr_frame;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_map_distributor u0 (.*);

    function automatic logic [63:0] exp_en(input logic [1:0] m, input int x, input int y,
                                           input logic [7:0] cm, input logic [7:0] rm);
        logic [63:0] e = '0;
        for (int r = 0; r < 8; r++) begin
            for (int c = 0; c < 8; c++) begin
                if (m == 2'b00 && c == x && r == y) e[r*8+c] = 1'b1;
                if (m == 2'b01) e[r*8+c] = 1'b1;
                if (m == 2'b10 && cm[c] && rm[r]) e[r*8+c] = 1'b1;
            end
        end
        return e;
    endfunction

    task automatic chk(input string req, input logic [143:0] act, input logic [143:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Offers one frame at a negedge, then checks the outputs at the next negedge.
    task automatic send(input string req, input logic [1:0] m, input int x, input int y,
                        input logic [9:0] z, input logic [7:0] cm, input logic [7:0] rm,
                        input logic [143:0] f);
        in_valid = 1'b1; in_mode = m; in_col = 3'(x); in_row = 3'(y);
        in_slot = z; in_colmask = cm; in_rowmask = rm; in_frame = f;
        @(negedge clk);
        chk(req, 144'(wr_en), 144'(exp_en(m, x, y, cm, rm)));
        if (m != 2'b11) begin
            chk({req, "/R9 slot"}, 144'(wr_slot), 144'(z));
            chk({req, "/R9 frame"}, wr_frame, f);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset strobes", 144'(wr_en), 144'(0));
        rst_n = 1'b1; load_en = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", 144'(wr_en), 144'(0));
    endtask

    task automatic t_single();
        send("R3 single 0,0", 2'b00, 0, 0, 10'd5, 8'h00, 8'h00, {9{16'h1234}});
        send("R3 single 7,7", 2'b00, 7, 7, 10'd1023, 8'hFF, 8'hFF, {9{16'hBEEF}});
        send("R3 single 3,5", 2'b00, 3, 5, 10'd77, 8'h00, 8'h00, {9{16'h0F0F}});
        in_valid = 1'b0;
        @(negedge clk);
        chk("R8 strobe drops", 144'(wr_en), 144'(0));
    endtask

    task automatic t_all();
        send("R4 broadcast", 2'b01, 2, 6, 10'd300, 8'h00, 8'h00, {9{16'hA5A5}});
        send("R4 broadcast other xy", 2'b01, 7, 0, 10'd0, 8'h12, 8'h34, {9{16'h5A5A}});
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_mask();
        send("R5 mask sparse", 2'b10, 0, 0, 10'd9, 8'b1000_0101, 8'b0100_0010, {9{16'hC001}});
        send("R5 mask full", 2'b10, 4, 4, 10'd10, 8'hFF, 8'hFF, {9{16'hC002}});
        send("R5 mask empty row", 2'b10, 4, 4, 10'd11, 8'hFF, 8'h00, {9{16'hC003}});
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_illegal();
        send("R6 illegal code", 2'b11, 1, 1, 10'd12, 8'hFF, 8'hFF, {9{16'hDEAD}});
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_switch();
        send("R7 switch single", 2'b00, 6, 1, 10'd20, 8'hFF, 8'hFF, {9{16'h0001}});
        send("R7 switch mask", 2'b10, 6, 1, 10'd21, 8'h0F, 8'hF0, {9{16'h0002}});
        send("R7 switch all", 2'b01, 6, 1, 10'd22, 8'h0F, 8'hF0, {9{16'h0003}});
        send("R7 switch single again", 2'b00, 1, 6, 10'd23, 8'h0F, 8'hF0, {9{16'h0004}});
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_unloaded();
        load_en = 1'b0;
        #1;
        chk("R2 ready low", 144'(in_ready), 144'(0));
        in_valid = 1'b1; in_mode = 2'b01; in_slot = 10'd40; in_frame = {9{16'hFFFF}};
        @(negedge clk);
        chk("R2 no strobe unloaded", 144'(wr_en), 144'(0));
        @(negedge clk);
        chk("R2 still none", 144'(wr_en), 144'(0));
        in_valid = 1'b0; load_en = 1'b1;
        #1;
        chk("R2 ready back", 144'(in_ready), 144'(1));
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_single();
        t_all();
        t_mask();
        t_illegal();
        t_switch();
        t_unloaded();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule